// File: doc/BRIEF.md
# Frame Interrupt Pulse Generator

This block makes the active-low maskable interrupt that a video chip raises once per frame. A strobe from the video timing marks the frame start. The interrupt then stays low for a number of CPU clock-enable ticks. That number comes from a width chosen by the machine model and loaded into a down counter when the pulse begins. The pixel clock runs the logic. With the CPU enable high on every other pixel clock, a 32-tick pulse lasts 64 pixel clocks.

The pulse can also travel through a shared expansion-bus pin. When the bus is enabled, the block drives the pin with the pulse. The CPU's interrupt input then takes the value read back from that pin, so a peripheral on the bus can hold the line high and suppress the interrupt. When the bus is off, the pin is released high and the CPU sees the internal pulse directly.

Top module: `frame_irq_gen`

## Requirements
- R1: While reset is held and after it is released, with no strobe, `cpu_int_n` and `xpin_drive` are both 1 and the counter is cleared.
- R2: A `frame_strobe` sampled high while no pulse is running starts a pulse. The internal interrupt is low from the next clock edge onwards.
- R3: With `model_sel` 2'b00 or 2'b11 the pulse lasts 32 CPU enable ticks. With the enable high on alternate clocks and the strobe on an enable cycle, that is 64 pixel clocks low.
- R4: With `model_sel` 2'b01 the pulse lasts 36 CPU enable ticks, which is 72 pixel clocks under the same conditions.
- R5: With `model_sel` 2'b10 the pulse lasts 37 CPU enable ticks, which is 74 pixel clocks under the same conditions.
- R6: A strobe that arrives while a pulse is running is ignored. The pulse ends on its original schedule, and only one pulse is produced.
- R7: The width is captured when the pulse starts. A change of `model_sel` during a pulse does not alter that pulse and takes effect at the next strobe.
- R8: With `xbus_en` 1, `xpin_drive` carries the pulse (low while it is active), and `cpu_int_n` equals `xpin_in`.
- R9: With `xbus_en` 1 and the pin held high by a peripheral, `cpu_int_n` stays 1 for the whole pulse.
- R10: With `xbus_en` 0, `xpin_drive` is 1 and `cpu_int_n` is low exactly while the internal pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | CPU clock enable, one pixel clock wide |
| frame_strobe | input | 1 | Frame-start position strobe |
| model_sel | input | 2 | Machine model: 00/11 base, 01 longer, 10 longer plus capacitive load |
| xbus_en | input | 1 | Expansion bus enable |
| xpin_in | input | 1 | Sampled value of the shared expansion interrupt pin |
| xpin_drive | output | 1 | Value driven onto the expansion interrupt pin |
| cpu_int_n | output | 1 | Active-low interrupt delivered to the CPU |

## Verification
The assertions assume that `cpu_ce` is a single-cycle qualifier, so that a running count can only move on a cycle where it is high. They also assume that `xpin_in` is an arbitrary external value, which the block only passes through and never registers. The stimulus toggles `cpu_ce` on every pixel clock and raises strobes only on enable cycles, so the pulse widths in pixel clocks are exact. With the bus enabled, the bench feeds `xpin_drive` back to `xpin_in` unless a peripheral hold is active, in which case the pin reads 1.

// File: rtl/frame_irq_gen.sv
module frame_irq_gen #(
  parameter int W_BASE = 32,
  parameter int W_ALT  = 36,
  parameter int W_CAP  = 37,
  localparam int WMAX  = (W_BASE > W_ALT) ? ((W_BASE > W_CAP) ? W_BASE : W_CAP)
                                          : ((W_ALT > W_CAP) ? W_ALT : W_CAP),
  localparam int CW    = $clog2(WMAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ce,
  input  logic       frame_strobe,
  input  logic [1:0] model_sel,
  input  logic       xbus_en,
  input  logic       xpin_in,
  output logic       xpin_drive,
  output logic       cpu_int_n
);

  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  always_comb begin
    case (model_sel)
      2'b01:   load_val = CW'(W_ALT);
      2'b10:   load_val = CW'(W_CAP);
      default: load_val = CW'(W_BASE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (frame_strobe) begin
        active <= 1'b1;
        cnt    <= load_val;
      end
    end else if (cpu_ce) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) active <= 1'b0;
    end
  end

  wire int_gen_n = ~active;

  assign xpin_drive = xbus_en ? int_gen_n : 1'b1;
  assign cpu_int_n  = xbus_en ? xpin_in   : int_gen_n;

endmodule

// File: rtl/frame_irq_gen_chk.sv
module frame_irq_gen_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ce,
  input logic          frame_strobe,
  input logic          xbus_en,
  input logic          xpin_in,
  input logic          xpin_drive,
  input logic          cpu_int_n,
  input logic          active,
  input logic [CW-1:0] cnt
);

  AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (cnt == '0 || $past(!active))) else $error("idle counter"); // R1

  AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && frame_strobe) |=> active) else $error("no start"); // R2

  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt != '0) else $error("zero count while active"); // R3

  AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cpu_ce) |=> (active && cnt == $past(cnt))) else $error("count moved"); // R6

  AST_PIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_en && active) |-> !xpin_drive) else $error("pin not driven"); // R8

  AST_PERIPH_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_en && xpin_in) |-> cpu_int_n) else $error("override lost"); // R9

  AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !xbus_en |-> (xpin_drive && (cpu_int_n == !active))) else $error("direct path"); // R10

endmodule

bind frame_irq_gen frame_irq_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .frame_strobe(frame_strobe),
  .xbus_en(xbus_en), .xpin_in(xpin_in), .xpin_drive(xpin_drive),
  .cpu_int_n(cpu_int_n), .active(active), .cnt(cnt)
);

// File: tb/tb_frame_irq_gen.sv
`timescale 1ns/1ps
module tb_frame_irq_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b0;
  logic       frame_strobe = 1'b0;
  logic [1:0] model_sel = 2'b00;
  logic       xbus_en = 1'b0;
  logic       xpin_in = 1'b1;
  logic       xpin_drive, cpu_int_n;
  logic       hold = 1'b0;

  int total = 0, bad = 0;
  int ref_act = 0, ref_rem = 0;
  int low_run = 0, last_len = 0, pulses = 0;
  logic prev_int = 1'b1;
  bit finished = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  frame_irq_gen dut (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .frame_strobe(frame_strobe),
    .model_sel(model_sel), .xbus_en(xbus_en), .xpin_in(xpin_in),
    .xpin_drive(xpin_drive), .cpu_int_n(cpu_int_n)
  );

  function automatic int wfor(input logic [1:0] m);
    if (m == 2'b01) return 36;
    if (m == 2'b10) return 37;
    return 32;
  endfunction

  task automatic check(input string r, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int e_int, e_pin;
    if (!rst_n) begin
      ref_act = 0; ref_rem = 0;
    end else if (ref_act == 0) begin
      if (frame_strobe) begin ref_act = 1; ref_rem = wfor(model_sel); end
    end else if (cpu_ce) begin
      ref_rem--;
      if (ref_rem == 0) ref_act = 0;
    end
    #1;
    e_int = xbus_en ? int'(xpin_in) : (ref_act == 0);
    e_pin = xbus_en ? (ref_act == 0) : 1;
    check(req, int'(cpu_int_n), e_int, "cpu_int_n");
    check(req, int'(xpin_drive), e_pin, "xpin_drive");
    if (!cpu_int_n) low_run++;
    else if (low_run != 0) begin last_len = low_run; low_run = 0; end
    if (prev_int && !cpu_int_n) pulses++;
    prev_int = cpu_int_n;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      cpu_ce = ~cpu_ce;
      frame_strobe = 1'b0;
      xpin_in = hold ? 1'b1 : xpin_drive;
    end
  endtask

  task automatic fire();
    do begin
      @(negedge clk);
      cpu_ce = ~cpu_ce;
      frame_strobe = cpu_ce;
      xpin_in = hold ? 1'b1 : xpin_drive;
    end while (!frame_strobe);
  endtask

  task automatic width_case(input logic [1:0] m, input int exp_len, input string r);
    req = r;
    model_sel = m;
    fire();
    step(90);
    check(r, last_len, exp_len, "pulse length");
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!finished) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    step(4);
    check("R1", int'(cpu_int_n), 1, "int during reset");
    check("R1", int'(xpin_drive), 1, "pin during reset");
    @(negedge clk); rst_n = 1'b1;
    step(6);
    check("R1", int'(cpu_int_n), 1, "int after reset");

    req = "R2";
    fire();
    @(negedge clk);
    check("R2", int'(cpu_int_n), 0, "int after strobe");
    step(90);

    width_case(2'b00, 64, "R3");
    width_case(2'b11, 64, "R3");
    width_case(2'b01, 72, "R4");
    width_case(2'b10, 74, "R5");

    req = "R6";
    model_sel = 2'b00;
    p0 = pulses;
    fire();
    step(11);
    fire();
    step(90);
    check("R6", last_len, 64, "length with extra strobe");
    check("R6", pulses - p0, 1, "pulse count");

    req = "R7";
    model_sel = 2'b00;
    fire();
    step(5);
    model_sel = 2'b10;
    step(90);
    check("R7", last_len, 64, "length after mid-pulse change");
    fire();
    step(90);
    check("R7", last_len, 74, "next frame uses new width");

    req = "R8";
    model_sel = 2'b00;
    xbus_en = 1'b1;
    step(2);
    fire();
    step(5);
    check("R8", int'(xpin_drive), 0, "pin carries pulse");
    check("R8", int'(cpu_int_n), int'(xpin_in), "int follows pin");
    step(90);
    check("R8", last_len, 64, "looped-back length");

    req = "R9";
    hold = 1'b1;
    p0 = pulses;
    fire();
    step(5);
    check("R9", int'(xpin_drive), 0, "pin still driven");
    check("R9", int'(cpu_int_n), 1, "int suppressed");
    step(90);
    check("R9", pulses - p0, 0, "no pulse seen by cpu");
    hold = 1'b0;

    req = "R10";
    xbus_en = 1'b0;
    step(2);
    xpin_in = 1'b0;
    fire();
    step(5);
    check("R10", int'(xpin_drive), 1, "pin released");
    check("R10", int'(cpu_int_n), 0, "direct int");
    step(90);
    check("R10", int'(cpu_int_n), 1, "direct int ends");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule